// File: doc/BRIEF.md
# Stack-Machine ALU with Nibble Shift

This block computes the two-operand operations of a byte-oriented stack machine: equality and magnitude tests, wrapping add, subtract and multiply, unsigned divide, the three bitwise operations, and a combined shift. The stack unit pops the operands, presents them with a 5-bit operation code and a short-mode flag, and pulses `start`. One clock later the block presents a registered result, a flag that tells whether that result is one byte or two, and a one-cycle valid strobe. Popping, pushing and keep-mode handling stay in the stack unit.

The operand order is `a op b`, where `b` is the value that was on top of the stack. In byte mode only the low byte of each operand is used. In short mode both operands are 16 bits wide, with two exceptions. Comparisons always return a single byte. The shift operation always takes a one-byte count.

The shift is unusual. The low nibble of the count byte gives a right-shift amount and the high nibble gives a left-shift amount. Both shifts are applied one after the other, right first, and zeros fill the vacated positions.

Top module: `stk_alu`

## Requirements
- R1: `res_valid` is high for exactly the one cycle after a cycle with `start` high. In every other cycle it is low. While `start` is low, `result` and `res_wide` keep their values.
- R2: Code 0x18 adds, 0x19 subtracts (`a - b`) and 0x1A multiplies. Each result is reduced modulo 2^8 in byte mode and modulo 2^16 in short mode, and no carry is kept.
- R3: Code 0x1B gives the unsigned quotient `a / b`, truncated toward zero. When `b` is zero the result is 0.
- R4: Codes 0x08 (equal), 0x09 (not equal), 0x0A (`a > b`) and 0x0B (`a < b`) compare without sign. Each result is 1 or 0 in bit 0, with all other bits zero, and `res_wide` is 0 even in short mode.
- R5: Code 0x1C gives bitwise AND, 0x1D bitwise OR and 0x1E bitwise exclusive OR, at the operand width.
- R6: Code 0x1F shifts `a` right by `b[3:0]`, then shifts that value left by `b[7:4]`. Vacated bits are zero, bits pushed out are lost, and the result is truncated to the operand width.
- R7: In short mode, code 0x1F shifts all 16 bits of `a` and takes its count only from `b[7:0]`. `b[15:8]` has no effect.
- R8: With `wide` low, bits 15:8 of both operands have no effect. `result[15:8]` is 0 and `res_wide` is 0.
- R9: Any code outside the twelve listed gives a result of 0 with `res_wide` 0, and still produces the valid strobe.
- R10: During reset, `result`, `res_wide` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operands and code are valid this cycle |
| op | input | 5 | Operation code |
| wide | input | 1 | Short mode: 16-bit operands |
| opnd_a | input | 16 | Deeper operand |
| opnd_b | input | 16 | Top-of-stack operand (shift count for code 0x1F) |
| result | output | 16 | Registered result |
| res_wide | output | 1 | 1 when `result` is a 16-bit value |
| res_valid | output | 1 | One-cycle strobe, one clock after `start` |

## Verification
The bench targets several mistakes:
- **Shift order and count.** Shifting left before right, or swapping the nibbles, loses high bits or keeps bits that should be gone. Counts of 8 or more in byte mode must empty the byte.
- **Byte-mode operand and result width.** Stray upper operand bytes in byte mode would change quotients and comparisons. An unmasked sum or product would leak into `result[15:8]`.
- **Divide by zero, zero count and unused code.** Divide by zero must give 0, not all ones. A zero shift count must leave `a` untouched. An unused code must give a clean zero.
- **Short-mode shift and compare.** A short-mode shift must ignore `b[15:8]`. A short-mode compare must still report a one-byte result.

// File: rtl/stk_alu_pkg.sv
package stk_alu_pkg;

   typedef enum logic [4:0] {
      OP_EQ  = 5'h08,
      OP_NE  = 5'h09,
      OP_GT  = 5'h0A,
      OP_LT  = 5'h0B,
      OP_ADD = 5'h18,
      OP_SUB = 5'h19,
      OP_MUL = 5'h1A,
      OP_DIV = 5'h1B,
      OP_AND = 5'h1C,
      OP_OR  = 5'h1D,
      OP_XOR = 5'h1E,
      OP_SFT = 5'h1F
   } alu_op_e;

   // Operation groups share the upper code bits; the low two bits pick the member.
   function automatic logic is_cmp(input logic [4:0] code);
      return code[4:2] == 3'b010;
   endfunction

   function automatic logic is_arith(input logic [4:0] code);
      return code[4:2] == 3'b110;
   endfunction

   function automatic logic is_bitop(input logic [4:0] code);
      return code[4:2] == 3'b111;
   endfunction

endpackage

// File: rtl/stk_alu_cmp.sv
module stk_alu_cmp #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic         flag
);
   always_comb begin
      unique case (sel)
         2'd0:    flag = (a == b);
         2'd1:    flag = (a != b);
         2'd2:    flag = (a > b);
         default: flag = (a < b);
      endcase
   end
endmodule

// File: rtl/stk_alu_arith.sv
module stk_alu_arith #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   sel,
   output logic [W-1:0] y
);
   logic [W-1:0] sum, diff, prod, quot;

   assign sum  = a + b;
   assign diff = a - b;
   assign prod = a * b;
   assign quot = (b == '0) ? '0 : a / b;

   always_comb begin
      unique case (sel)
         2'd0:    y = sum;
         2'd1:    y = diff;
         2'd2:    y = prod;
         default: y = quot;
      endcase
   end
endmodule

// File: rtl/stk_alu_logic.sv
module stk_alu_logic #(
   parameter int W     = 16,
   parameter int CNT_W = 4
) (
   input  logic [W-1:0]       a,
   input  logic [W-1:0]       b,
   input  logic [2*CNT_W-1:0] cnt,
   input  logic [1:0]         sel,
   output logic [W-1:0]       y
);
   // Barrel stages: right by cnt[CNT_W-1:0] first, then left by the upper field.
   logic [CNT_W:0][W-1:0] rsh;
   logic [CNT_W:0][W-1:0] lsh;

   assign rsh[0] = a;
   assign lsh[0] = rsh[CNT_W];

   for (genvar g = 0; g < CNT_W; g++) begin : g_stage
      assign rsh[g+1] = cnt[g]         ? (rsh[g] >> (1 << g)) : rsh[g];
      assign lsh[g+1] = cnt[CNT_W + g] ? (lsh[g] << (1 << g)) : lsh[g];
   end

   always_comb begin
      unique case (sel)
         2'd0:    y = a & b;
         2'd1:    y = a | b;
         2'd2:    y = a ^ b;
         default: y = lsh[CNT_W];
      endcase
   end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
   import stk_alu_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [4:0]            op,
   input  logic                  wide,
   input  logic [2*BYTE_W-1:0]   opnd_a,
   input  logic [2*BYTE_W-1:0]   opnd_b,
   output logic [2*BYTE_W-1:0]   result,
   output logic                  res_wide,
   output logic                  res_valid
);
   localparam int W     = 2 * BYTE_W;
   localparam int CNT_W = BYTE_W / 2;

   if (BYTE_W < 4 || (BYTE_W % 2) != 0) begin : g_bad_width
      $error("stk_alu: BYTE_W must be even and at least 4");
   end

   logic [W-1:0] a_m, b_m, arith_y, logic_y;
   logic [W-1:0] nxt_res, nxt_masked;
   logic         cmp_flag, nxt_wide;

   assign a_m = wide ? opnd_a : {{BYTE_W{1'b0}}, opnd_a[BYTE_W-1:0]};
   assign b_m = wide ? opnd_b : {{BYTE_W{1'b0}}, opnd_b[BYTE_W-1:0]};

   stk_alu_cmp #(.W(W)) u_cmp (
      .a(a_m), .b(b_m), .sel(op[1:0]), .flag(cmp_flag)
   );

   stk_alu_arith #(.W(W)) u_arith (
      .a(a_m), .b(b_m), .sel(op[1:0]), .y(arith_y)
   );

   stk_alu_logic #(.W(W), .CNT_W(CNT_W)) u_logic (
      .a(a_m), .b(b_m), .cnt(opnd_b[BYTE_W-1:0]), .sel(op[1:0]), .y(logic_y)
   );

   always_comb begin
      nxt_res  = '0;
      nxt_wide = 1'b0;
      if (is_cmp(op)) begin
         nxt_res = {{(W-1){1'b0}}, cmp_flag};
      end else if (is_arith(op)) begin
         nxt_res  = arith_y;
         nxt_wide = wide;
      end else if (is_bitop(op)) begin
         nxt_res  = logic_y;
         nxt_wide = wide;
      end
      nxt_masked = nxt_wide ? nxt_res : {{BYTE_W{1'b0}}, nxt_res[BYTE_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         res_wide  <= 1'b0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= start;
         if (start) begin
            result   <= nxt_masked;
            res_wide <= nxt_wide;
         end
      end
   end
endmodule

// File: rtl/stk_alu_chk.sv
module stk_alu_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic [4:0]          op,
   input logic                wide,
   input logic [2*BYTE_W-1:0] opnd_a,
   input logic [2*BYTE_W-1:0] opnd_b,
   input logic [2*BYTE_W-1:0] result,
   input logic                res_wide,
   input logic                res_valid
);
   localparam int W = 2 * BYTE_W;

   logic b_zero;
   assign b_zero = wide ? (opnd_b == '0) : (opnd_b[BYTE_W-1:0] == '0);

   assert_valid_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> res_valid);

   assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !res_valid);

   assert_result_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(result) && $stable(res_wide)));

   assert_div_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op == 5'h1B && b_zero) |=> (result == '0));

   assert_cmp_boolean_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op[4:2] == 3'b010) |=> (result[W-1:1] == '0 && !res_wide));

   assert_byte_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !wide) |=> (result[W-1:BYTE_W] == '0 && !res_wide));

   assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && op[3] == 1'b0) |=> (result == '0 && !res_wide));
endmodule

bind stk_alu stk_alu_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
   .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
   .res_wide(res_wide), .res_valid(res_valid)
);

// File: tb/test_stk_alu.sv
`timescale 1ns/1ps
module test_stk_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  op = '0;
   logic        wide = 1'b0;
   logic [15:0] opnd_a = '0;
   logic [15:0] opnd_b = '0;
   logic [15:0] result;
   logic        res_wide;
   logic        res_valid;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #5 clk = ~clk;

   stk_alu i_stk_alu (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
      .res_wide(res_wide), .res_valid(res_valid)
   );

   // Reference model: returns {wide flag, value}
   function automatic logic [16:0] model(input logic [4:0] c, input logic w,
                                         input logic [15:0] a, input logic [15:0] b);
      logic [31:0] av, bv, v;
      logic [15:0] mask;
      logic        rw;
      mask = w ? 16'hFFFF : 16'h00FF;
      av = {16'h0, a & mask};
      bv = {16'h0, b & mask};
      rw = w;
      case (c)
         5'h08: begin v = (av == bv) ? 1 : 0; rw = 0; end
         5'h09: begin v = (av != bv) ? 1 : 0; rw = 0; end
         5'h0A: begin v = (av >  bv) ? 1 : 0; rw = 0; end
         5'h0B: begin v = (av <  bv) ? 1 : 0; rw = 0; end
         5'h18: v = av + bv;
         5'h19: v = av - bv;
         5'h1A: v = av * bv;
         5'h1B: v = (bv == 0) ? 0 : av / bv;
         5'h1C: v = av & bv;
         5'h1D: v = av | bv;
         5'h1E: v = av ^ bv;
         5'h1F: begin v = av >> b[3:0]; v = v << b[7:4]; end
         default: begin v = 0; rw = 0; end
      endcase
      return {rw, v[15:0] & (rw ? 16'hFFFF : 16'h00FF)};
   endfunction

   function automatic string tag_of(input logic [4:0] c);
      case (c)
         5'h08, 5'h09, 5'h0A, 5'h0B: return "R4";
         5'h18, 5'h19, 5'h1A:        return "R2";
         5'h1B:                      return "R3";
         5'h1C, 5'h1D, 5'h1E:        return "R5";
         5'h1F:                      return "R6";
         default:                    return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got valid/wide/result=%h expected %h", tag, got, exp);
      end
   endtask

   task automatic run(input logic [4:0] c, input logic w, input logic [15:0] a,
                      input logic [15:0] b, input string tag);
      logic [16:0] e;
      logic [15:0] held;
      @(negedge clk);
      op = c; wide = w; opnd_a = a; opnd_b = b; start = 1'b1;
      e = model(c, w, a, b);
      @(negedge clk);
      start = 1'b0;
      opnd_a = ~a; opnd_b = ~b; op = 5'h18;
      check(tag, {res_valid, res_wide, result}, {1'b1, e});
      held = result;
      @(negedge clk);
      // R1: strobe drops, outputs hold while start is low
      check("R1", {res_valid, res_wide, result}, {1'b0, e[16], held});
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", {res_valid, res_wide, result}, 18'h0);
      rst_n = 1'b1;

      // Directed corner cases
      run(5'h1F, 1'b0, 16'h00B6, 16'h0021, "R6");   // right 1 then left 2
      run(5'h1F, 1'b0, 16'h00FF, 16'h0080, "R6");   // left 8 empties a byte
      run(5'h1F, 1'b0, 16'h005A, 16'h0000, "R6");   // zero count
      run(5'h1F, 1'b0, 16'h0081, 16'h0007, "R6");   // right 7
      run(5'h1F, 1'b1, 16'hF00F, 16'hAB34, "R7");   // short, upper b ignored
      run(5'h1F, 1'b1, 16'h8001, 16'h00F0, "R7");
      run(5'h1B, 1'b0, 16'h0037, 16'h0000, "R3");
      run(5'h1B, 1'b1, 16'hFFFF, 16'h0000, "R3");
      run(5'h1B, 1'b0, 16'h00C8, 16'h0700, "R3");   // byte-mode b is zero
      run(5'h1B, 1'b1, 16'hFFFF, 16'h0010, "R3");
      run(5'h18, 1'b0, 16'h00FF, 16'h0001, "R2");
      run(5'h18, 1'b1, 16'hFFFF, 16'h0002, "R2");
      run(5'h19, 1'b0, 16'h0000, 16'h0001, "R2");
      run(5'h1A, 1'b1, 16'h1234, 16'h5678, "R2");
      run(5'h0A, 1'b1, 16'h8000, 16'h7FFF, "R4");
      run(5'h0B, 1'b1, 16'h0100, 16'h00FF, "R4");
      run(5'h08, 1'b0, 16'h1234, 16'h5634, "R8");   // upper bytes differ, byte equal
      run(5'h1D, 1'b0, 16'hAA0F, 16'h55F0, "R8");
      run(5'h1E, 1'b1, 16'hA5A5, 16'h0FF0, "R5");
      run(5'h00, 1'b1, 16'hFFFF, 16'hFFFF, "R9");
      run(5'h13, 1'b0, 16'h00FF, 16'h0001, "R9");

      // Constrained random
      for (int i = 0; i < 1500; i++) begin
         int k;
         logic [4:0] c;
         k = $urandom_range(0, 12);
         if (k < 4)       c = 5'(8 + k);
         else if (k < 12) c = 5'(16'h18 + k - 4);
         else             c = 5'($urandom_range(0, 7));
         run(c, 1'($urandom_range(0, 1)), 16'($urandom), 16'($urandom), tag_of(c));
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule